// File: doc/BRIEF.md
# Frame-Synchronous Shadow Register Bank for Display Windows

This block holds the configuration of each display window twice. Writes from the register port always land in a shadow copy. The fetch and overlay logic sees only the active copy. The shadow copy of a window moves into the active copy at a frame boundary, which is the rising edge of the vsync input. This is the same moment the next frame's fetch begins, so a frame never starts with half-written settings.

A transfer happens only after software asks for one by writing the update register. The request arms every window at once. At the next vsync rising edge, every armed window whose protect bit is clear copies its shadow into its active copy, and its armed flag clears. A protected window stays armed. It transfers at the first vsync after its protect bit is cleared, with no new request needed. Software can therefore set protect, rewrite several fields of a window, and release it without the fetch ever seeing a mix of old and new values. Turning a window off is an ordinary shadow write to its enable bit, so the window stays visible until the frame boundary.

A one-cycle done pulse marks each frame boundary at which at least one window transferred.

Top module: `shreg_bank`

## Requirements
- R1: After reset, every active field of every window is zero, every protect bit is clear, no window is armed, and xfer_done is low.
- R2: Register writes never change the active outputs directly. Address bit 4 = 0 selects window configuration: bit 3 is the window and bits 2:0 select the field. The field codes are 0 base address (data[31:0]), 1 whole width, 2 whole height, 3 x offset, 4 y offset (each data[12:0]), 5 top-left corner, 6 bottom-right corner (x in data[12:0], y in data[28:16]), and 7 control (enable data[0], format data[11:8]).
- R3: Writing address 0x11 with data[0] = 1 arms all windows. At the next vsync rising edge, each armed, unprotected window copies all of its shadow fields to its active outputs. The new values are visible after that clock edge. xfer_done is high for exactly the one following cycle.
- R4: A vsync rising edge with no window armed changes no active output and leaves xfer_done low.
- R5: The armed flag of a window clears when that window transfers. A later vsync with no new request does not move shadow values written after the transfer.
- R6: Writing address 0x10 loads the protect mask from data[1:0], with bit w for window w. A protected window does not transfer at vsync and stays armed. An unprotected armed window transfers at the same vsync.
- R7: When the protect bit of an armed window is cleared, the window transfers at the next vsync rising edge without a new request.
- R8: vsync is edge detected. Holding it high for many cycles gives at most one transfer. A request made while vsync stays high waits for the next rising edge.
- R9: Clearing the enable bit of a window takes effect on act_en only at the vsync transfer. Until then the window stays enabled.
- R10: A shadow write to a window in the same cycle as that window's transfer is kept out of the transfer. The active copy takes the older shadow value, and the window stays armed, so the new value moves at the following vsync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Frame sync, synchronous to clk; its rising edge is the frame boundary |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write address (1 + log2(NUM_WIN) + 3 bits) |
| wr_data | input | 32 | Write data |
| act_base | output | NUM_WIN x 32 | Active buffer start address per window |
| act_whole_w | output | NUM_WIN x 13 | Active whole buffer width |
| act_whole_h | output | NUM_WIN x 13 | Active whole buffer height |
| act_off_x | output | NUM_WIN x 13 | Active x offset in the buffer |
| act_off_y | output | NUM_WIN x 13 | Active y offset in the buffer |
| act_tl_x | output | NUM_WIN x 13 | Active top-left corner x |
| act_tl_y | output | NUM_WIN x 13 | Active top-left corner y |
| act_br_x | output | NUM_WIN x 13 | Active bottom-right corner x |
| act_br_y | output | NUM_WIN x 13 | Active bottom-right corner y |
| act_fmt | output | NUM_WIN x 4 | Active pixel format code |
| act_en | output | NUM_WIN | Active window enable |
| xfer_done | output | 1 | One-cycle pulse after a frame boundary at which any window transferred |

## Verification
The assertions check four rules on every cycle. An active window's base and enable never change without that window's transfer. A protected window never transfers. An enable drops only together with a done pulse. The done pulse lasts one cycle and follows a cycle with vsync high. Other behaviour needs the bench's scenarios because it depends on history over many cycles:
- a request is needed before anything moves, and it clears itself after the transfer;
- a window released from protect transfers later with no new request;
- a held vsync gives a single transfer;
- a write that collides with a transfer moves one frame later;
- every field sits at its documented bit position.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  parameter int BASE_W  = 32;
  parameter int DIM_W   = 13;
  parameter int FMT_W   = 4;
  parameter int DATA_W  = 32;
  parameter int FIELD_W = 3;

  localparam int Y_LSB   = 16;
  localparam int FMT_LSB = 8;

  typedef enum logic [FIELD_W-1:0] {
    F_BASE     = 3'd0,
    F_WHOLE_W  = 3'd1,
    F_WHOLE_H  = 3'd2,
    F_OFF_X    = 3'd3,
    F_OFF_Y    = 3'd4,
    F_TOPLEFT  = 3'd5,
    F_BOTRIGHT = 3'd6,
    F_CTRL     = 3'd7
  } field_e;

  localparam logic [FIELD_W-1:0] G_PROTECT = 3'd0;
  localparam logic [FIELD_W-1:0] G_UPDATE  = 3'd1;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [DIM_W-1:0]  whole_w;
    logic [DIM_W-1:0]  whole_h;
    logic [DIM_W-1:0]  off_x;
    logic [DIM_W-1:0]  off_y;
    logic [DIM_W-1:0]  tl_x;
    logic [DIM_W-1:0]  tl_y;
    logic [DIM_W-1:0]  br_x;
    logic [DIM_W-1:0]  br_y;
    logic [FMT_W-1:0]  fmt;
    logic              en;
  } win_cfg_t;

  // Merge one register write into a window configuration.
  function automatic win_cfg_t apply_field(input win_cfg_t cur, input field_e f,
                                           input logic [DATA_W-1:0] d);
    win_cfg_t n;
    n = cur;
    case (f)
      F_BASE:     n.base    = d[BASE_W-1:0];
      F_WHOLE_W:  n.whole_w = d[DIM_W-1:0];
      F_WHOLE_H:  n.whole_h = d[DIM_W-1:0];
      F_OFF_X:    n.off_x   = d[DIM_W-1:0];
      F_OFF_Y:    n.off_y   = d[DIM_W-1:0];
      F_TOPLEFT: begin
        n.tl_x = d[DIM_W-1:0];
        n.tl_y = d[Y_LSB +: DIM_W];
      end
      F_BOTRIGHT: begin
        n.br_x = d[DIM_W-1:0];
        n.br_y = d[Y_LSB +: DIM_W];
      end
      F_CTRL: begin
        n.en  = d[0];
        n.fmt = d[FMT_LSB +: FMT_W];
      end
      default: n = cur;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/shreg_vsync_edge.sv
module shreg_vsync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync,
  output logic vs_rise
);
  logic vs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) vs_q <= 1'b0;
    else        vs_q <= vsync;
  end

  assign vs_rise = vsync & ~vs_q;
endmodule

// File: rtl/shreg_wr_dec.sv
module shreg_wr_dec
  import shreg_pkg::*;
#(
  parameter int NUM_WIN  = 2,
  parameter int WIN_BITS = 1,
  parameter int ADDR_W   = 5
) (
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic               upd_bit,
  output logic [NUM_WIN-1:0] win_hit,
  output field_e             field,
  output logic               prot_we,
  output logic               upd_arm
);
  logic                glob;
  logic [WIN_BITS-1:0] widx;
  logic [FIELD_W-1:0]  low;

  assign glob  = wr_addr[ADDR_W-1];
  assign widx  = wr_addr[FIELD_W +: WIN_BITS];
  assign low   = wr_addr[FIELD_W-1:0];
  assign field = field_e'(low);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_hit
    assign win_hit[w] = wr_en & ~glob & (widx == WIN_BITS'(w));
  end

  assign prot_we = wr_en & glob & (low == G_PROTECT);
  assign upd_arm = wr_en & glob & (low == G_UPDATE) & upd_bit;
endmodule

// File: rtl/shreg_win.sv
module shreg_win
  import shreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  field_e            wr_field,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              arm,
  input  logic              protect,
  input  logic              vs_rise,
  output win_cfg_t          active,
  output logic              xfer
);
  win_cfg_t shadow_q;
  win_cfg_t active_q;
  logic     pend_q;

  assign xfer   = vs_rise & pend_q & ~protect;
  assign active = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (wr_hit) shadow_q <= apply_field(shadow_q, wr_field, wr_data);
      if (xfer)   active_q <= shadow_q;
      // a write colliding with the transfer keeps the window armed
      if (arm)                  pend_q <= 1'b1;
      else if (xfer && !wr_hit) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/shreg_bank.sv
module shreg_bank
  import shreg_pkg::*;
#(
  parameter  int NUM_WIN  = 2,
  localparam int WIN_BITS = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int ADDR_W   = 1 + WIN_BITS + FIELD_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            vsync,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [NUM_WIN-1:0][BASE_W-1:0]  act_base,
  output logic [NUM_WIN-1:0][DIM_W-1:0]   act_whole_w,
  output logic [NUM_WIN-1:0][DIM_W-1:0]   act_whole_h,
  output logic [NUM_WIN-1:0][DIM_W-1:0]   act_off_x,
  output logic [NUM_WIN-1:0][DIM_W-1:0]   act_off_y,
  output logic [NUM_WIN-1:0][DIM_W-1:0]   act_tl_x,
  output logic [NUM_WIN-1:0][DIM_W-1:0]   act_tl_y,
  output logic [NUM_WIN-1:0][DIM_W-1:0]   act_br_x,
  output logic [NUM_WIN-1:0][DIM_W-1:0]   act_br_y,
  output logic [NUM_WIN-1:0][FMT_W-1:0]   act_fmt,
  output logic [NUM_WIN-1:0]              act_en,
  output logic                            xfer_done
);
  logic               vs_rise;
  logic [NUM_WIN-1:0] win_hit;
  field_e             wr_field;
  logic               prot_we;
  logic               upd_arm;
  logic [NUM_WIN-1:0] prot_q;
  logic [NUM_WIN-1:0] win_xfer;
  win_cfg_t           act_cfg [NUM_WIN];

  shreg_vsync_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .vsync   (vsync),
    .vs_rise (vs_rise)
  );

  shreg_wr_dec #(.NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS), .ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .upd_bit (wr_data[0]),
    .win_hit (win_hit),
    .field   (wr_field),
    .prot_we (prot_we),
    .upd_arm (upd_arm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q    <= '0;
      xfer_done <= 1'b0;
    end else begin
      if (prot_we) prot_q <= wr_data[NUM_WIN-1:0];
      xfer_done <= |win_xfer;
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    shreg_win u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (win_hit[w]),
      .wr_field (wr_field),
      .wr_data  (wr_data),
      .arm      (upd_arm),
      .protect  (prot_q[w]),
      .vs_rise  (vs_rise),
      .active   (act_cfg[w]),
      .xfer     (win_xfer[w])
    );
    assign act_base[w]    = act_cfg[w].base;
    assign act_whole_w[w] = act_cfg[w].whole_w;
    assign act_whole_h[w] = act_cfg[w].whole_h;
    assign act_off_x[w]   = act_cfg[w].off_x;
    assign act_off_y[w]   = act_cfg[w].off_y;
    assign act_tl_x[w]    = act_cfg[w].tl_x;
    assign act_tl_y[w]    = act_cfg[w].tl_y;
    assign act_br_x[w]    = act_cfg[w].br_x;
    assign act_br_y[w]    = act_cfg[w].br_y;
    assign act_fmt[w]     = act_cfg[w].fmt;
    assign act_en[w]      = act_cfg[w].en;
  end
endmodule

// File: rtl/shreg_bank_chk.sv
module shreg_bank_chk
  import shreg_pkg::*;
#(
  parameter int NUM_WIN = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           vsync,
  input logic [NUM_WIN-1:0]             win_xfer,
  input logic [NUM_WIN-1:0]             prot_q,
  input logic [NUM_WIN-1:0][BASE_W-1:0] act_base,
  input logic [NUM_WIN-1:0]             act_en,
  input logic                           xfer_done
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_w
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !win_xfer[w] |=> ($stable(act_base[w]) && $stable(act_en[w])));

    assert_protect_R6: assert property (@(posedge clk) disable iff (!rst_n)
      prot_q[w] |-> !win_xfer[w]);

    assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act_en[w]) |-> xfer_done);
  end

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  assert_done_vsync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> $past(vsync));
endmodule

bind shreg_bank shreg_bank_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vsync     (vsync),
  .win_xfer  (win_xfer),
  .prot_q    (prot_q),
  .act_base  (act_base),
  .act_en    (act_en),
  .xfer_done (xfer_done)
);

// File: tb/shreg_bank_tb.sv
`timescale 1ns/1ps
module shreg_bank_tb;
  import shreg_pkg::*;

  localparam int NW = 2;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [NW-1:0][BASE_W-1:0] act_base;
  logic [NW-1:0][DIM_W-1:0]  act_whole_w, act_whole_h, act_off_x, act_off_y;
  logic [NW-1:0][DIM_W-1:0]  act_tl_x, act_tl_y, act_br_x, act_br_y;
  logic [NW-1:0][FMT_W-1:0]  act_fmt;
  logic [NW-1:0]             act_en;
  logic                      xfer_done;

  always #10 clk = ~clk;

  shreg_bank #(.NUM_WIN(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .act_base(act_base), .act_whole_w(act_whole_w),
    .act_whole_h(act_whole_h), .act_off_x(act_off_x), .act_off_y(act_off_y),
    .act_tl_x(act_tl_x), .act_tl_y(act_tl_y), .act_br_x(act_br_x),
    .act_br_y(act_br_y), .act_fmt(act_fmt), .act_en(act_en), .xfer_done(xfer_done)
  );

  typedef struct {
    win_cfg_t act [NW];
    logic     done;
    string    tag;
  } exp_t;

  exp_t     sb_q [$];
  win_cfg_t m_sh  [NW];
  win_cfg_t m_act [NW];
  logic     m_pend [NW];
  logic [NW-1:0] m_prot;
  logic     m_vs_q;
  logic     m_done;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Independent restatement of the field map from R2.
  function automatic win_cfg_t mdl_write(input win_cfg_t c, input int f, input logic [31:0] d);
    win_cfg_t r = c;
    if (f == 0) r.base = d;
    if (f == 1) r.whole_w = d[12:0];
    if (f == 2) r.whole_h = d[12:0];
    if (f == 3) r.off_x = d[12:0];
    if (f == 4) r.off_y = d[12:0];
    if (f == 5) begin r.tl_x = d[12:0]; r.tl_y = d[28:16]; end
    if (f == 6) begin r.br_x = d[12:0]; r.br_y = d[28:16]; end
    if (f == 7) begin r.en = d[0]; r.fmt = d[11:8]; end
    return r;
  endfunction

  task automatic step(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                      input logic vs, input string tag);
    logic rise;
    logic [NW-1:0] x;
    logic hit;
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; vsync = vs;
    @(posedge clk);
    rise = vs & ~m_vs_q;
    m_vs_q = vs;
    x = '0;
    for (int w = 0; w < NW; w++)
      if (rise && m_pend[w] && !m_prot[w]) begin
        x[w] = 1'b1;
        m_act[w] = m_sh[w];
      end
    m_done = |x;
    for (int w = 0; w < NW; w++) begin
      hit = we && !a[4] && (int'(a[3]) == w);
      if (x[w] && !hit) m_pend[w] = 1'b0;
    end
    if (we && !a[4]) m_sh[a[3]] = mdl_write(m_sh[a[3]], int'(a[2:0]), d);
    if (we && a == 5'h10) m_prot = d[NW-1:0];
    if (we && a == 5'h11 && d[0])
      for (int w = 0; w < NW; w++) m_pend[w] = 1'b1;
    #1;
    for (int w = 0; w < NW; w++) e.act[w] = m_act[w];
    e.done = m_done;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    step(1'b1, a, d, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic vs_pulse(input string tag);
    step(1'b0, '0, '0, 1'b1, tag);
    step(1'b0, '0, '0, 1'b0, tag);
  endtask

  // Monitor: compares the scoreboard head against the outputs mid-cycle.
  exp_t     mon_e;
  win_cfg_t mon_got;
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      mon_e = sb_q.pop_front();
      for (int w = 0; w < NW; w++) begin
        mon_got.base = act_base[w];       mon_got.whole_w = act_whole_w[w];
        mon_got.whole_h = act_whole_h[w]; mon_got.off_x = act_off_x[w];
        mon_got.off_y = act_off_y[w];     mon_got.tl_x = act_tl_x[w];
        mon_got.tl_y = act_tl_y[w];       mon_got.br_x = act_br_x[w];
        mon_got.br_y = act_br_y[w];       mon_got.fmt = act_fmt[w];
        mon_got.en = act_en[w];
        total++;
        if (mon_got !== mon_e.act[w]) begin
          bad++;
          $display("FAIL %s window%0d active actual=%h expected=%h", mon_e.tag, w,
                   mon_got, mon_e.act[w]);
        end
      end
      total++;
      if (xfer_done !== mon_e.done) begin
        bad++;
        $display("FAIL %s xfer_done actual=%b expected=%b", mon_e.tag, xfer_done, mon_e.done);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      m_sh[w] = '0; m_act[w] = '0; m_pend[w] = 1'b0;
    end
    m_prot = '0; m_vs_q = 1'b0; m_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    repeat (3) idle("R1");

    // R2: shadow writes do not reach the outputs
    wr(5'h00, 32'h8000_1000, "R2");
    wr(5'h01, 32'h0000_0500, "R2");
    wr(5'h02, 32'h0000_02D0, "R2");
    wr(5'h03, 32'h0000_0011, "R2");
    wr(5'h04, 32'h0000_0022, "R2");
    wr(5'h05, 32'h0040_0030, "R2");
    wr(5'h06, 32'h0120_0230, "R2");
    wr(5'h07, 32'h0000_0301, "R2");
    wr(5'h08, 32'h9000_0000, "R2");
    wr(5'h0F, 32'h0000_0501, "R2");
    idle("R2");

    // R4: vsync without a request
    vs_pulse("R4");

    // R3: request then vsync moves everything, done pulses once
    wr(5'h11, 32'h1, "R3");
    idle("R3");
    vs_pulse("R3");
    idle("R3");

    // R5: request self-clears
    wr(5'h00, 32'h8000_2000, "R5");
    vs_pulse("R5");
    idle("R5");

    // R6: protect window 0, window 1 still moves
    wr(5'h10, 32'h1, "R6");
    wr(5'h08, 32'h9000_4000, "R6");
    wr(5'h11, 32'h1, "R6");
    vs_pulse("R6");
    vs_pulse("R6");

    // R7: release protect, window 0 moves with no new request
    wr(5'h10, 32'h0, "R7");
    idle("R7");
    vs_pulse("R7");
    idle("R7");

    // R8: held vsync gives a single transfer
    wr(5'h09, 32'h0000_0100, "R8");
    wr(5'h11, 32'h1, "R8");
    step(1'b0, '0, '0, 1'b1, "R8");
    step(1'b1, 5'h09, 32'h0000_0200, 1'b1, "R8");
    step(1'b1, 5'h11, 32'h1, 1'b1, "R8");
    repeat (4) step(1'b0, '0, '0, 1'b1, "R8");
    step(1'b0, '0, '0, 1'b0, "R8");
    vs_pulse("R8");

    // R9: disable only at the frame boundary
    wr(5'h0F, 32'h0000_0500, "R9");
    wr(5'h11, 32'h1, "R9");
    repeat (3) idle("R9");
    vs_pulse("R9");

    // R10: write in the transfer cycle is held to the next frame
    wr(5'h00, 32'h8000_A000, "R10");
    wr(5'h11, 32'h1, "R10");
    step(1'b1, 5'h00, 32'h8000_B000, 1'b1, "R10");
    step(1'b0, '0, '0, 1'b0, "R10");
    vs_pulse("R10");
    vs_pulse("R10");

    repeat (2) @(negedge clk);
    @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule